// File: doc/BRIEF.md
# Oversampled serial receiver with timed status events

This block recovers characters from an asynchronous serial line. An external baud generator supplies a one-cycle enable at sixteen times the bit rate, and the receiver samples the line on each enable. Every bit is resolved by a majority vote over three samples near its middle. Five character layouts can be selected: 7, 8 or 9 data bits, and the 7-bit and 8-bit layouts can each carry a trailing parity bit. Each character ends with one stop bit.

A received character first builds up in a shift register. It is then copied into a holding register, which software reads through a read strobe. Each status event is raised at a fixed sample point inside the frame. The receive interrupt, the framing error and the overrun error are decided at the middle of the stop bit. The parity error is decided at the middle of the parity bit. The error flags stay set until a clear strobe.

The format, the parity sense and the enable are captured when a start bit is detected. A change to these inputs during a frame therefore has no effect on the frame in progress.

Top module: `uart_rx_timed`

## Requirements
- R1: `fmt` selects the character layout. 0 gives 9 data bits. 1 gives 8 data bits plus parity. 2 gives 8 data bits. 3 gives 7 data bits. 4 gives 7 data bits plus parity. The values 5 to 7 behave as 2. Data arrives least significant bit first and is presented right-aligned on `data_out`, with the unused upper bits zero.
- R2: `rx_irq` is high for exactly one clock. That clock follows the enable tick carrying sample 9 of the stop bit. It pulses once per accepted character.
- R3: `err_frame` is set at the stop-bit decision point when the voted stop bit is 0.
- R4: `err_parity` is set at the decision point of the parity bit when the number of ones over the data and parity bits is wrong. With `par_odd`=1 the count must be odd. With `par_odd`=0 it must be even. The flag is never set in layouts without a parity bit.
- R5: `err_overrun` is set at the stop-bit decision point if the holding register still holds an unread character.
- R6: `fmt`, `par_odd` and `rx_en` are sampled only when a start bit is detected. A change during a frame does not alter that frame. Clearing `rx_en` stops reception only after the current frame ends.
- R7: Within each bit, sample 0 is the tick on which the bit begins. The bit value is the majority of samples 7, 8 and 9, so a single corrupted sample among them is tolerated.
- R8: A frame starts on an enabled tick that sees the line low while idle. If the voted start bit is 1, the receiver returns to idle and reports nothing.
- R9: The error flags stay set until `clr_stb`. A flag being set in the same clock wins over the clear. `rd_stb` marks the holding register as read. On an overrun the holding register still takes the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | Oversampling enable, 16 per bit |
| fmt | input | 3 | Character layout select |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_en | input | 1 | Receive enable |
| rd_stb | input | 1 | Holding register read strobe |
| clr_stb | input | 1 | Clears the error flags |
| data_out | output | 9 | Holding register contents |
| rx_irq | output | 1 | Receive-complete pulse |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
Two cases are hard to reach from the ports. The first is a configuration change in the middle of a frame. The second is a vote that has to override one bad sample. The stimulus places every line transition on a specific enable tick, so it can corrupt exactly sample 8 of each data bit. At a fixed tick inside the fourth bit it flips the layout, flips the parity sense and drops the enable. A behavioural model in the bench knows which tick carries each decision point and compares all outputs on every clock. Any event that fires one tick early or late, or under the wrong configuration, is therefore caught.

// File: rtl/uart_rx_timed.sv
module uart_rx_timed #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic [2:0] fmt,
  input  logic       par_odd,
  input  logic       rx_en,
  input  logic       rd_stb,
  input  logic       clr_stb,
  output logic [8:0] data_out,
  output logic       rx_irq,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] S_MID  = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] S_V1   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_V2   = CW'(OVS / 2);
  localparam logic [CW-1:0] S_LAST = CW'(OVS - 1);

  logic          busy, full, v1, v2, pacc;
  logic          par_q, odd_q;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx, nbits_q;
  logic [8:0]    shf;
  logic [3:0]    nb_in;
  logic          par_in;

  always_comb begin
    case (fmt)
      3'd0:    begin nb_in = 4'd9; par_in = 1'b0; end
      3'd1:    begin nb_in = 4'd8; par_in = 1'b1; end
      3'd3:    begin nb_in = 4'd7; par_in = 1'b0; end
      3'd4:    begin nb_in = 4'd7; par_in = 1'b1; end
      default: begin nb_in = 4'd8; par_in = 1'b0; end
    endcase
  end

  wire [CW-1:0] cur     = cnt + 1'b1;
  wire          vote    = (v1 & v2) | (v1 & rxd) | (v2 & rxd);
  wire          at_mid  = tick && busy && cur == S_MID;
  wire          is_data = bidx >= 4'd1 && bidx <= nbits_q;
  wire          is_par  = par_q && bidx == nbits_q + 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; full <= 1'b0; cnt <= '0; bidx <= '0;
      nbits_q <= 4'd8; par_q <= 1'b0; odd_q <= 1'b0;
      v1 <= 1'b1; v2 <= 1'b1; pacc <= 1'b0; shf <= '0;
      data_out <= '0; rx_irq <= 1'b0;
      err_frame <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (rd_stb) full <= 1'b0;
      if (clr_stb) begin
        err_frame <= 1'b0; err_parity <= 1'b0; err_overrun <= 1'b0;
      end
      if (tick && !busy) begin
        if (rx_en && !rxd) begin
          busy <= 1'b1; cnt <= '0; bidx <= '0;
          nbits_q <= nb_in; par_q <= par_in; odd_q <= par_odd;
          shf <= '0; pacc <= 1'b0;
        end
      end else if (tick) begin
        cnt <= cur;
        if (cur == S_V1) v1 <= rxd;
        if (cur == S_V2) v2 <= rxd;
        if (cur == S_LAST) bidx <= bidx + 4'd1;
      end
      if (at_mid) begin
        if (bidx == 4'd0) begin
          if (vote) busy <= 1'b0;
        end else if (is_data) begin
          shf  <= {vote, shf[8:1]};
          pacc <= pacc ^ vote;
        end else if (is_par) begin
          if ((pacc ^ vote) != odd_q) err_parity <= 1'b1;
        end else begin
          busy     <= 1'b0;
          rx_irq   <= 1'b1;
          data_out <= shf >> (4'd9 - nbits_q);
          full     <= 1'b1;
          if (!vote) err_frame <= 1'b1;
          if (full && !rd_stb) err_overrun <= 1'b1;
        end
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R2
  AST_FRAME_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> rx_irq); // R3
  AST_PARITY_ONLY_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> $past(busy && par_q)); // R4
  AST_OVERRUN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> rx_irq); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(nbits_q) && $stable(par_q) && $stable(odd_q))); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy); // R6
  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick && !rxd)); // R8

endmodule

// File: tb/uart_rx_timed_bench.sv
module uart_rx_timed_bench;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick = 1'b0;
  logic [2:0] fmt = 3'd2;
  logic par_odd = 1'b0, rx_en = 1'b1, rd_stb = 1'b0, clr_stb = 1'b0;
  logic [8:0] data_out;
  logic rx_irq, err_frame, err_parity, err_overrun;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  logic ev_stop = 0, ev_stopv = 1, ev_perr = 0;
  logic [8:0] ev_word = '0;
  logic [8:0] e_data;
  logic e_irq, e_fe, e_pe, e_oe, e_full;

  always #5 clk = ~clk;

  uart_rx_timed u_uart_rx_timed (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .fmt(fmt),
    .par_odd(par_odd), .rx_en(rx_en), .rd_stb(rd_stb), .clr_stb(clr_stb),
    .data_out(data_out), .rx_irq(rx_irq), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun));

  always @(posedge clk) begin
    if (!rst_n) begin
      e_data <= '0; e_irq <= 0; e_fe <= 0; e_pe <= 0; e_oe <= 0; e_full <= 0;
    end else begin
      e_irq <= 0;
      if (rd_stb) e_full <= 0;
      if (clr_stb) begin e_fe <= 0; e_pe <= 0; e_oe <= 0; end
      if (tick && ev_perr) e_pe <= 1;
      if (tick && ev_stop) begin
        e_irq <= 1; e_data <= ev_word; e_full <= 1;
        if (!ev_stopv) e_fe <= 1;
        if (e_full && !rd_stb) e_oe <= 1;
      end
    end
  end

  task automatic cmp(input string rq, input string nm, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h t=%0t", rq, phase, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("R1", "data_out", data_out, e_data);
    cmp("R2", "rx_irq", {8'd0, rx_irq}, {8'd0, e_irq});
    cmp("R3", "err_frame", {8'd0, err_frame}, {8'd0, e_fe});
    cmp("R4", "err_parity", {8'd0, err_parity}, {8'd0, e_pe});
    cmp("R5", "err_overrun", {8'd0, err_overrun}, {8'd0, e_oe});
  end

  task automatic do_tick(input logic line);
    @(negedge clk); rxd = line; tick = 1;
    @(negedge clk); tick = 0; ev_stop = 0; ev_perr = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) do_tick(1'b1);
  endtask

  task automatic strobe(input bit rd, input bit clr);
    @(negedge clk); rd_stb = rd; clr_stb = clr;
    @(negedge clk); rd_stb = 0; clr_stb = 0;
  endtask

  task automatic send(input logic [8:0] w, input logic [2:0] f, input logic odd,
                      input bit bad_par, input bit bad_stop, input bit glitch,
                      input bit scramble, input bit expect_rx);
    int n, p, nb;
    logic b [0:11];
    logic [8:0] m;
    n = (f == 3'd0) ? 9 : (f == 3'd3 || f == 3'd4) ? 7 : 8;
    p = (f == 3'd1 || f == 3'd4) ? 1 : 0;
    nb = n + p + 2;
    m = 9'((1 << n) - 1);
    fmt = f; par_odd = odd;
    b[0] = 0;
    for (int i = 0; i < n; i++) b[i + 1] = w[i];
    if (p == 1) b[n + 1] = (^(w & m)) ^ odd ^ bad_par;
    b[nb - 1] = ~bad_stop;
    for (int i = 0; i < nb; i++) begin
      for (int s = 0; s < 16; s++) begin
        logic line;
        line = b[i];
        if (glitch && i >= 1 && i <= n && s == 8) line = ~line;
        if (bad_stop && i == nb - 1 && s > 9) line = 1;
        if (scramble && i == 3 && s == 0) begin
          fmt = fmt ^ 3'd3; par_odd = ~par_odd; rx_en = 0;
        end
        if (expect_rx && s == 9) begin
          if (i == nb - 1) begin ev_stop = 1; ev_stopv = b[i]; ev_word = w & m; end
          if (p == 1 && i == n + 1 && bad_par) ev_perr = 1;
        end
        @(negedge clk); rxd = line; tick = 1;
        @(negedge clk); tick = 0; ev_stop = 0; ev_perr = 0;
      end
    end
    idle(3);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog (phase %s) actual=timeout expected=finish", phase);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reset data_out", data_out, 9'd0);
    cmp("R2", "reset rx_irq", {8'd0, rx_irq}, 9'd0);
    cmp("R9", "reset flags", {6'd0, err_frame, err_parity, err_overrun}, 9'd0);
    rst_n = 1;
    idle(4);
    phase = "R1";
    send(9'h0A5, 3'd2, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    send(9'h1C3, 3'd0, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    send(9'h07E, 3'd3, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    send(9'h1FF, 3'd7, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    phase = "R4";
    send(9'h05A, 3'd1, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    send(9'h031, 3'd4, 1, 0, 0, 0, 0, 1); strobe(1, 0);
    send(9'h0C3, 3'd1, 1, 1, 0, 0, 0, 1); strobe(1, 0);
    phase = "R9";
    strobe(0, 1);
    phase = "R4";
    send(9'h02B, 3'd4, 0, 1, 0, 0, 0, 1); strobe(1, 1);
    phase = "R3";
    send(9'h066, 3'd2, 0, 0, 1, 0, 0, 1); strobe(1, 0);
    phase = "R9";
    strobe(0, 1);
    phase = "R5";
    send(9'h011, 3'd2, 0, 0, 0, 0, 0, 1);
    send(9'h022, 3'd2, 0, 0, 0, 0, 0, 1);
    phase = "R9";
    strobe(1, 0); strobe(0, 1);
    send(9'h044, 3'd2, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    phase = "R7";
    send(9'h0B6, 3'd2, 0, 0, 0, 1, 0, 1); strobe(1, 0);
    send(9'h12D, 3'd0, 0, 0, 0, 1, 0, 1); strobe(1, 0);
    phase = "R8";
    for (int s = 0; s < 16; s++) do_tick(s < 8 ? 1'b0 : 1'b1);
    idle(4);
    send(9'h099, 3'd2, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    phase = "R6";
    send(9'h04D, 3'd1, 0, 0, 0, 0, 1, 1); strobe(1, 0);
    send(9'h0F0, 3'd2, 0, 0, 0, 0, 0, 0);
    rx_en = 1;
    idle(2);
    send(9'h00F, 3'd2, 0, 0, 0, 0, 0, 1); strobe(1, 0);
    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule